// File: doc/BRIEF.md
# Mirrored Lookup Table Bank Access Unit

This block sits between two table clients, a host processor port and a search engine port, and a pair of synchronous SRAM banks. The banks hold identical copies of the switch's lookup tables, such as the address-learning table and the VLAN index table. Every table update is mirrored. The unit holds the update in a one-entry write slot and commits it to both banks in one cycle, only when both banks report themselves free. Every read goes to a single bank, to whichever one can take it that cycle, so a read never waits for one particular bank.

Each client has a request/acknowledge handshake. A request is taken in the cycle its acknowledge is high. When both clients request in the same cycle, the search engine wins and the processor keeps its request up. A read whose address matches the update still waiting in the slot is held back until that update has reached both banks, so a read never returns an old entry. Read results come back on one shared response port. Each result is tagged with the client that asked for it and arrives a fixed number of cycles after the request was taken.

Each bank takes an enable, a write flag, an address and write data. It reports a free flag for the current cycle and returns read data one cycle after an enabled read. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the unit starts working on the second rising edge after the release.

Top module: `tbl_mirror_unit`

## Requirements
- R1: After reset the write slot is empty, no bank enable is high, no response is valid, and no acknowledge is high while no client requests.
- R2: A write request is acknowledged only while the write slot is empty. When the slot is committed, both banks see enable=1 and write=1 in the same cycle, with identical address and data equal to the acknowledged request.
- R3: A held write is committed only in a cycle where both bank free flags are 1. In any other cycle neither bank receives that write and it stays in the slot.
- R4: A read is sent to exactly one bank: bank A when A is free and no write is committing, otherwise bank B when B is free and no write is committing. A read never enables both banks.
- R5: A read whose address equals the address of the write held in the slot is not acknowledged until that write has committed.
- R6: The response for a read acknowledged in cycle t is valid in cycle t+2. Its tag is 0 for a processor read and 1 for a search engine read.
- R7: When both clients request in the same cycle, only the search engine can be acknowledged in that cycle.
- R8: Read data equals the most recent committed write to that address (zero if none), whichever bank served the read.
- R9: A read is not acknowledged in a cycle where no bank is available to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | AW | Processor table address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ack | output | 1 | Processor request taken this cycle |
| se_req | input | 1 | Search engine request |
| se_we | input | 1 | Search engine request is a write |
| se_addr | input | AW | Search engine table address |
| se_wdata | input | DW | Search engine write data |
| se_ack | output | 1 | Search engine request taken this cycle |
| bka_free | input | 1 | Bank A can accept an access this cycle |
| bka_en | output | 1 | Bank A access enable |
| bka_we | output | 1 | Bank A write flag |
| bka_addr | output | AW | Bank A address |
| bka_wdata | output | DW | Bank A write data |
| bka_rdata | input | DW | Bank A read data, one cycle after a read enable |
| bkb_free | input | 1 | Bank B can accept an access this cycle |
| bkb_en | output | 1 | Bank B access enable |
| bkb_we | output | 1 | Bank B write flag |
| bkb_addr | output | AW | Bank B address |
| bkb_wdata | output | DW | Bank B write data |
| bkb_rdata | input | DW | Bank B read data, one cycle after a read enable |
| rsp_valid | output | 1 | Read response valid |
| rsp_src | output | 1 | Response tag: 0 processor, 1 search engine |
| rsp_data | output | DW | Read response data |

## Verification
Acknowledges and bank enables depend combinationally on the requests, the free flags and the slot state. They are due in the same cycle as the stimulus, so the bench compares them one time step after it drives the inputs at the falling edge. A write sits in the slot for at least one cycle, and its bank commit is expected in the first later cycle in which both banks are free. A read response is due exactly two cycles after its acknowledge: one cycle for the bank read and one for the response register. The bench keeps a queue of expected responses, each stamped with its due cycle, and checks the response port against the head of that queue every cycle. A response that arrives early, late or not at all therefore counts as a miscompare.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_SE  = 1'b1
  } src_e;
endpackage

// File: rtl/tmu_arb.sv
module tmu_arb
  import tmu_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          se_req,
  input  logic          se_we,
  input  logic [AW-1:0] se_addr,
  input  logic [DW-1:0] se_wdata,
  input  logic          slot_vld,
  input  logic [AW-1:0] slot_addr,
  input  logic          a_free,
  input  logic          b_free,
  output logic          cpu_ack,
  output logic          se_ack,
  output src_e          win_src,
  output logic [AW-1:0] win_addr,
  output logic [DW-1:0] win_wdata,
  output logic          wr_accept,
  output logic          wr_issue,
  output logic          rd_go,
  output logic          rd_sel_b
);
  logic any_req, win_we, rd_a_ok, rd_b_ok, hazard, take;

  always_comb begin
    any_req   = cpu_req | se_req;
    win_src   = se_req ? SRC_SE : SRC_CPU;
    win_we    = se_req ? se_we    : cpu_we;
    win_addr  = se_req ? se_addr  : cpu_addr;
    win_wdata = se_req ? se_wdata : cpu_wdata;
    wr_issue  = slot_vld & a_free & b_free;
    rd_a_ok   = a_free & ~wr_issue;
    rd_b_ok   = b_free & ~wr_issue;
    hazard    = slot_vld && (slot_addr == win_addr);
    wr_accept = any_req & win_we & ~slot_vld;
    rd_go     = any_req & ~win_we & ~hazard & (rd_a_ok | rd_b_ok);
    rd_sel_b  = ~rd_a_ok;
    take      = wr_accept | rd_go;
    se_ack    = take & (win_src == SRC_SE);
    cpu_ack   = take & (win_src == SRC_CPU);
  end

  // R7
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({cpu_ack, se_ack}));

  // R7
  se_first_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_req && se_req) |-> !cpu_ack);

  // R5
  no_stale_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (slot_vld && se_req && !se_we && se_addr == slot_addr) |-> !se_ack);
endmodule

// File: rtl/tmu_wslot.sv
module tmu_wslot #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          issue,
  output logic          slot_vld,
  output logic [AW-1:0] slot_addr,
  output logic [DW-1:0] slot_data
);
  logic vld_nxt;

  always_comb begin
    vld_nxt = slot_vld;
    if (issue) vld_nxt = 1'b0;
    if (load)  vld_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) slot_vld <= 1'b0;
    else         slot_vld <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      slot_addr <= ld_addr;
      slot_data <= ld_data;
    end
  end

  // R3
  held_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (slot_vld && !issue) |=> (slot_vld && $stable(slot_addr) && $stable(slot_data)));

  // R2
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    load |-> !slot_vld);
endmodule

// File: rtl/tmu_rdpipe.sv
module tmu_rdpipe
  import tmu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          rd_go,
  input  src_e          rd_src,
  input  logic          rd_sel_b,
  input  logic [DW-1:0] a_rdata,
  input  logic [DW-1:0] b_rdata,
  output logic          rsp_valid,
  output src_e          rsp_src,
  output logic [DW-1:0] rsp_data
);
  logic          p1_vld, p1_vld_nxt, rsp_vld_nxt;
  src_e          p1_src;
  logic          p1_selb;
  logic [DW-1:0] data_nxt;

  always_comb begin
    p1_vld_nxt  = rd_go;
    rsp_vld_nxt = p1_vld;
    data_nxt    = p1_selb ? b_rdata : a_rdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      p1_vld    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      p1_vld    <= p1_vld_nxt;
      rsp_valid <= rsp_vld_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_go) begin
      p1_src  <= rd_src;
      p1_selb <= rd_sel_b;
    end
    if (p1_vld) begin
      rsp_src  <= p1_src;
      rsp_data <= data_nxt;
    end
  end

  // R6
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_go |-> ##2 rsp_valid);

  // R6
  rsp_tag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_go |-> ##2 (rsp_src == $past(rd_src, 2)));
endmodule

// File: rtl/tbl_mirror_unit.sv
module tbl_mirror_unit
  import tmu_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  input  logic          se_req,
  input  logic          se_we,
  input  logic [AW-1:0] se_addr,
  input  logic [DW-1:0] se_wdata,
  output logic          se_ack,
  input  logic          bka_free,
  output logic          bka_en,
  output logic          bka_we,
  output logic [AW-1:0] bka_addr,
  output logic [DW-1:0] bka_wdata,
  input  logic [DW-1:0] bka_rdata,
  input  logic          bkb_free,
  output logic          bkb_en,
  output logic          bkb_we,
  output logic [AW-1:0] bkb_addr,
  output logic [DW-1:0] bkb_wdata,
  input  logic [DW-1:0] bkb_rdata,
  output logic          rsp_valid,
  output logic          rsp_src,
  output logic [DW-1:0] rsp_data
);
  logic [1:0]    rst_pipe;
  logic          rst_sn;
  logic          slot_vld, wr_accept, wr_issue, rd_go, rd_sel_b;
  logic [AW-1:0] slot_addr, win_addr;
  logic [DW-1:0] slot_data, win_wdata;
  src_e          win_src, rsp_src_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  tmu_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_sn(rst_sn),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .se_req(se_req), .se_we(se_we), .se_addr(se_addr), .se_wdata(se_wdata),
    .slot_vld(slot_vld), .slot_addr(slot_addr),
    .a_free(bka_free), .b_free(bkb_free),
    .cpu_ack(cpu_ack), .se_ack(se_ack),
    .win_src(win_src), .win_addr(win_addr), .win_wdata(win_wdata),
    .wr_accept(wr_accept), .wr_issue(wr_issue),
    .rd_go(rd_go), .rd_sel_b(rd_sel_b)
  );

  tmu_wslot #(.AW(AW), .DW(DW)) u_wslot (
    .clk(clk), .rst_sn(rst_sn),
    .load(wr_accept), .ld_addr(win_addr), .ld_data(win_wdata),
    .issue(wr_issue),
    .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_data(slot_data)
  );

  tmu_rdpipe #(.DW(DW)) u_rdpipe (
    .clk(clk), .rst_sn(rst_sn),
    .rd_go(rd_go), .rd_src(win_src), .rd_sel_b(rd_sel_b),
    .a_rdata(bka_rdata), .b_rdata(bkb_rdata),
    .rsp_valid(rsp_valid), .rsp_src(rsp_src_e), .rsp_data(rsp_data)
  );

  always_comb begin
    bka_en    = wr_issue | (rd_go & ~rd_sel_b);
    bkb_en    = wr_issue | (rd_go &  rd_sel_b);
    bka_we    = wr_issue;
    bkb_we    = wr_issue;
    bka_addr  = wr_issue ? slot_addr : win_addr;
    bkb_addr  = wr_issue ? slot_addr : win_addr;
    bka_wdata = slot_data;
    bkb_wdata = slot_data;
    rsp_src   = rsp_src_e;
  end

  // R3
  a_free_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    bka_en |-> bka_free);

  // R3
  b_free_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    bkb_en |-> bkb_free);

  // R4
  one_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_go) |-> $onehot({bka_en, bkb_en}));

  // R2
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bka_en && bka_we) |-> (bkb_en && bkb_we));
endmodule

// File: tb/tbl_mirror_unit_tb.sv
module tbl_mirror_unit_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 0, cpu_we = 0, se_req = 0, se_we = 0;
  logic [AW-1:0] cpu_addr = '0, se_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, se_wdata = '0;
  logic          bka_free = 0, bkb_free = 0;
  logic          cpu_ack, se_ack, bka_en, bka_we, bkb_en, bkb_we;
  logic [AW-1:0] bka_addr, bkb_addr;
  logic [DW-1:0] bka_wdata, bkb_wdata;
  logic [DW-1:0] bka_rdata = '0, bkb_rdata = '0;
  logic          rsp_valid, rsp_src;
  logic [DW-1:0] rsp_data;

  always #4 clk = ~clk;

  tbl_mirror_unit #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .se_req(se_req), .se_we(se_we), .se_addr(se_addr), .se_wdata(se_wdata), .se_ack(se_ack),
    .bka_free(bka_free), .bka_en(bka_en), .bka_we(bka_we), .bka_addr(bka_addr),
    .bka_wdata(bka_wdata), .bka_rdata(bka_rdata),
    .bkb_free(bkb_free), .bkb_en(bkb_en), .bkb_we(bkb_we), .bkb_addr(bkb_addr),
    .bkb_wdata(bkb_wdata), .bkb_rdata(bkb_rdata),
    .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_data(rsp_data)
  );

  // behavioural bank memories
  logic [DW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_b [DEPTH];
  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem_a[i] = '0; mem_b[i] = '0; end
  end
  always @(posedge clk) begin
    if (bka_en) begin
      if (bka_we) mem_a[bka_addr] <= bka_wdata; else bka_rdata <= mem_a[bka_addr];
    end
    if (bkb_en) begin
      if (bkb_we) mem_b[bkb_addr] <= bkb_wdata; else bkb_rdata <= mem_b[bkb_addr];
    end
  end

  // reference model state
  typedef struct { int due; int src; int data; } exp_t;
  exp_t q[$];
  int   shadow [DEPTH];
  bit   m_vld = 0;
  int   m_addr = 0, m_data = 0;
  int   cyc = 0;
  int   n_vec = 0, n_bad = 0;
  bit   done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input bit cr, input bit cw, input int ca, input int cd,
                      input bit sr, input bit sw, input int sa, input int sd,
                      input bit af, input bit bf);
    bit wi, wse, we, aok, bok, haz, wacc, rgo, selb, ea, eb;
    int ad, dd;
    @(negedge clk);
    cpu_req = cr; cpu_we = cw; cpu_addr = AW'(ca); cpu_wdata = DW'(cd);
    se_req = sr; se_we = sw; se_addr = AW'(sa); se_wdata = DW'(sd);
    bka_free = af; bkb_free = bf;
    #1;
    ca = ca % DEPTH; sa = sa % DEPTH; cd = cd & 16'hFFFF; sd = sd & 16'hFFFF;
    wi   = m_vld && af && bf;
    wse  = sr;
    we   = sr ? sw : cw;
    ad   = sr ? sa : ca;
    dd   = sr ? sd : cd;
    aok  = af && !wi;
    bok  = bf && !wi;
    haz  = m_vld && (m_addr == ad);
    wacc = (cr || sr) && we && !m_vld;
    rgo  = (cr || sr) && !we && !haz && (aok || bok);
    selb = !aok;
    ea   = wi || (rgo && !selb);
    eb   = wi || (rgo && selb);
    // R7 R5 R9 R2: acknowledges
    chk("R7 se_ack", se_ack, (wacc || rgo) && wse);
    chk("R7 cpu_ack", cpu_ack, (wacc || rgo) && !wse);
    // R3 R4: bank enables
    chk("R3/R4 bka_en", bka_en, ea);
    chk("R3/R4 bkb_en", bkb_en, eb);
    if (wi) begin
      // R2: mirrored commit
      chk("R2 bka_we", bka_we, 1);
      chk("R2 bkb_we", bkb_we, 1);
      chk("R2 bka_addr", bka_addr, m_addr);
      chk("R2 bkb_addr", bkb_addr, m_addr);
      chk("R2 bka_wdata", bka_wdata, m_data);
      chk("R2 bkb_wdata", bkb_wdata, m_data);
    end else if (rgo) begin
      chk("R4 read we", selb ? bkb_we : bka_we, 0);
      chk("R4 read addr", selb ? bkb_addr : bka_addr, ad);
    end
    // R6 R8: responses
    if (q.size() > 0 && q[0].due == cyc) begin
      chk("R6 rsp_valid", rsp_valid, 1);
      chk("R6 rsp_src", rsp_src, q[0].src);
      chk("R8 rsp_data", rsp_data, q[0].data);
      void'(q.pop_front());
    end else begin
      chk("R6 rsp_valid idle", rsp_valid, 0);
    end
    @(posedge clk);
    if (wi) begin shadow[m_addr] = m_data; m_vld = 0; end
    if (wacc) begin m_vld = 1; m_addr = ad; m_data = dd; end
    if (rgo) q.push_back('{due: cyc + 2, src: int'(wse), data: shadow[ad]});
    cyc++;
  endtask

  task automatic idle(input bit af, input bit bf);
    step(0, 0, 0, 0, 0, 0, 0, 0, af, bf);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..: run did not complete");
      report();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R1: reset state, all idle
    idle(1, 1);
    idle(1, 1);
    // R2: processor write with both banks free, committed next cycle
    step(1, 1, 5, 16'h1234, 0, 0, 0, 0, 1, 1);
    idle(1, 1);
    // R8 R4: read back through bank A (both free)
    step(1, 0, 5, 0, 0, 0, 0, 0, 1, 1);
    // R4: read steered to bank B when A busy
    step(0, 0, 0, 0, 1, 0, 5, 0, 0, 1);
    // R9: no bank free, no acknowledge
    step(1, 0, 5, 0, 0, 0, 0, 0, 0, 0);
    idle(1, 1); idle(1, 1);
    // R3: search engine write held while only one bank free
    step(0, 0, 0, 0, 1, 1, 9, 16'hBEEF, 1, 1);
    idle(1, 0);
    idle(0, 1);
    // R5: read to held address stalls; other address proceeds on A
    step(1, 0, 9, 0, 0, 0, 0, 0, 1, 0);
    step(1, 0, 7, 0, 0, 0, 0, 0, 1, 0);
    // R3: commit once both free
    idle(1, 1);
    // R5 R8: read now returns new value
    step(1, 0, 9, 0, 0, 0, 0, 0, 0, 1);
    // R7: simultaneous requests, search engine wins
    step(1, 0, 5, 0, 1, 0, 9, 0, 1, 1);
    step(1, 1, 3, 16'h0AA0, 1, 1, 4, 16'h0550, 1, 1);
    // R2: write while slot full is not acknowledged
    step(1, 1, 3, 16'h0AA0, 0, 0, 0, 0, 0, 0);
    idle(1, 1);
    idle(1, 1); idle(1, 1);
    // mixed traffic on a small address range
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 65535),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 65535),
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
    end
    for (int n = 0; n < 4; n++) idle(1, 1);
    done = 1;
    report();
  end
endmodule